// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the decision core of an on-chip debug trigger. It walks through three arming states toward a Final state, driven by match events from three address/data comparators that sit outside it. Each match is either force-type or tag-type. A force-type match is held until the next instruction-boundary strobe from the CPU pipeline, and it takes effect there. A tag-type match is held until the tagged opcode reaches execution, which the pipeline signals through a per-comparator tag-execute strobe.

Software programs a next-state map. For every non-final state and every comparator, the map names the state that an effective match leads to. A software trigger input bypasses the comparators and sends the sequencer straight to Final. On entry to Final the block issues a one-cycle breakpoint request and a one-cycle trace-start pulse, each enabled separately. The trace-start pulse is withheld while the device is secured. The sequencer stays in Final until software disarms it. Disarming returns it to the first state and discards every pending match.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset, `state_o` reads 0 (first state) and `trace_start_o` and `brk_req_o` are low.
- R2: State codes are 0 = first, 1 = second, 2 = third, 3 = Final. Comparators are numbered 0 (A), 1 (B) and 2 (C). The target for state s (0..2) and comparator c sits at bits [(s*3+c)*2 +: 2] of `next_map_i`. A target equal to the current state leaves the state unchanged.
- R3: A force-type match (`cmp_hit_i[c]` high with `cmp_tag_i[c]` low) takes effect only at a `boundary_i` strobe in a later cycle, never in the same cycle. The state changes at the clock edge that ends that boundary cycle.
- R4: A tag-type match (`cmp_tag_i[c]` high) takes effect only when `tag_exec_i[c]` is high in a later cycle. `boundary_i` has no effect on it.
- R5: When several comparators take effect in the same cycle, comparator A wins over B, and B wins over C.
- R6: While armed and not in Final, `trig_i` moves the state to Final at the next edge, whatever the comparators show.
- R7: The cycle after Final is entered, `brk_req_o` is high for exactly one cycle if `brk_en_i` was high. `trace_start_o` is high for exactly one cycle if `trace_en_i` was high and `secure_i` was low in the entry cycle.
- R8: `secure_i` suppresses only the trace-start pulse. The breakpoint request is unaffected.
- R9: While armed, Final is held. Matches and `trig_i` give no further state change and no further pulses.
- R10: With `arm_i` low, the state returns to 0 at the next edge. Every pending match is discarded. Hits and `trig_i` seen while disarmed have no effect.
- R11: A pending match is consumed when it takes effect, even if it loses the priority contest. A boundary consumes every pending force match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | High: sequencer armed; low: disarm and return to first state |
| trig_i | input | 1 | Software trigger, jump to Final |
| secure_i | input | 1 | Device secured; suppresses trace start |
| trace_en_i | input | 1 | Enable trace-start pulse on Final entry |
| brk_en_i | input | 1 | Enable breakpoint request on Final entry |
| next_map_i | input | 18 | Next-state map, 2-bit target per state and comparator |
| cmp_hit_i | input | 3 | Match pulse per comparator |
| cmp_tag_i | input | 3 | Match type per comparator: 1 tag, 0 force |
| boundary_i | input | 1 | Instruction-boundary strobe |
| tag_exec_i | input | 3 | Tagged opcode of comparator c reached execution |
| state_o | output | 2 | Current sequencer state |
| trace_start_o | output | 1 | One-cycle trace-start pulse |
| brk_req_o | output | 1 | One-cycle breakpoint request |

## Verification
A wrong state shows on `state_o` at the next edge after the faulty decision, because the state register drives that port directly. A lost or stale pending flag stays hidden until the next boundary or tag-execute strobe. It then shows as a missing or unexpected transition one cycle after the strobe, so the stimulus holds matches pending across several idle cycles, disarms, and clears them. Faults in pulse generation appear as a wrong value of `trace_start_o` or `brk_req_o` in the cycle right after Final is entered, or as a pulse that repeats in the cycle after that.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
    localparam int unsigned SEQ_STATES = 4;
    localparam int unsigned SEQ_ARMING = SEQ_STATES - 1;
    localparam int unsigned TGT_W      = 2;

    typedef enum logic [TGT_W-1:0] {
        SEQ_S1    = 2'd0,
        SEQ_S2    = 2'd1,
        SEQ_S3    = 2'd2,
        SEQ_FINAL = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       trace;
        logic       brk;
    } seq_regs_t;
endpackage

// File: rtl/dbg_seq_pend.sv
module dbg_seq_pend #(
    parameter int unsigned NUM_CMP = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               arm_i,
    input  logic [NUM_CMP-1:0] hit_i,
    input  logic [NUM_CMP-1:0] tag_i,
    input  logic               boundary_i,
    input  logic [NUM_CMP-1:0] tag_exec_i,
    output logic [NUM_CMP-1:0] eff_o
);
    typedef struct packed {
        logic [NUM_CMP-1:0] frc;
        logic [NUM_CMP-1:0] tgd;
    } pend_t;

    pend_t pend_d, pend_q;

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_eff
        assign eff_o[c] = (pend_q.frc[c] & boundary_i) | (pend_q.tgd[c] & tag_exec_i[c]);
    end

    always_comb begin
        pend_d = pend_q;
        for (int c = 0; c < NUM_CMP; c++) begin
            if (!arm_i) begin
                pend_d.frc[c] = 1'b0;
                pend_d.tgd[c] = 1'b0;
            end else begin
                pend_d.frc[c] = (pend_q.frc[c] & ~boundary_i) | (hit_i[c] & ~tag_i[c]);
                pend_d.tgd[c] = (pend_q.tgd[c] & ~tag_exec_i[c]) | (hit_i[c] & tag_i[c]);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= pend_d;
    end

    // R10
    pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !arm_i |=> (pend_q == '0));

    // R3
    force_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q.frc == '0) |-> ((eff_o & ~(pend_q.tgd & tag_exec_i)) == '0));

    // R11
    force_consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (boundary_i && arm_i && !(|(hit_i & ~tag_i))) |=> (pend_q.frc == '0));
endmodule

// File: rtl/dbg_seq_arb.sv
module dbg_seq_arb
    import dbg_seq_pkg::*;
#(
    parameter int unsigned NUM_CMP = 3,
    localparam int unsigned MAP_W  = SEQ_ARMING * NUM_CMP * TGT_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  seq_state_e         state_i,
    input  logic [NUM_CMP-1:0] eff_i,
    input  logic [MAP_W-1:0]   map_i,
    output logic               sel_valid_o,
    output seq_state_e         sel_target_o
);
    logic [NUM_CMP-1:0] grant;
    logic [TGT_W-1:0]   fld;

    always_comb begin
        grant = '0;
        for (int c = 0; c < NUM_CMP; c++) begin
            if (eff_i[c] && (grant == '0)) grant[c] = 1'b1;
        end
    end

    always_comb begin
        fld = '0;
        if (state_i != SEQ_FINAL) begin
            for (int c = 0; c < NUM_CMP; c++) begin
                if (grant[c]) fld = map_i[(int'(state_i) * NUM_CMP + c) * TGT_W +: TGT_W];
            end
        end
    end

    assign sel_valid_o  = (grant != '0) && (state_i != SEQ_FINAL);
    assign sel_target_o = seq_state_e'(fld);

    // R5
    grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant));

    // R5
    grant_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eff_i[0] |-> grant[0]);
endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
    import dbg_seq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       arm_i,
    input  logic       trig_i,
    input  logic       secure_i,
    input  logic       trace_en_i,
    input  logic       brk_en_i,
    input  logic       sel_valid_i,
    input  seq_state_e sel_target_i,
    output seq_state_e state_o,
    output logic       trace_o,
    output logic       brk_o
);
    seq_regs_t regs_d, regs_q;
    logic      enter_final;

    always_comb begin
        regs_d       = regs_q;
        regs_d.trace = 1'b0;
        regs_d.brk   = 1'b0;
        if (!arm_i) begin
            regs_d.state = SEQ_S1;
        end else if (regs_q.state != SEQ_FINAL) begin
            if (trig_i)           regs_d.state = SEQ_FINAL;
            else if (sel_valid_i) regs_d.state = sel_target_i;
        end
        enter_final  = (regs_q.state != SEQ_FINAL) && (regs_d.state == SEQ_FINAL);
        regs_d.trace = enter_final & trace_en_i & ~secure_i;
        regs_d.brk   = enter_final & brk_en_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '{state: SEQ_S1, trace: 1'b0, brk: 1'b0};
        else         regs_q <= regs_d;
    end

    assign state_o = regs_q.state;
    assign trace_o = regs_q.trace;
    assign brk_o   = regs_q.brk;

    // R8
    trace_secure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trace_o |-> $past(!secure_i));

    // R7
    brk_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brk_o |=> !brk_o);

    // R7
    brk_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brk_o |-> (state_o == SEQ_FINAL) && ($past(state_o) != SEQ_FINAL));

    // R9
    final_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == SEQ_FINAL && arm_i) |=> (state_o == SEQ_FINAL));

    // R10
    disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !arm_i |=> (state_o == SEQ_S1) && !trace_o && !brk_o);

    // R6
    trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm_i && trig_i) |=> (state_o == SEQ_FINAL));
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
    import dbg_seq_pkg::*;
#(
    parameter int unsigned NUM_CMP = 3,
    localparam int unsigned MAP_W  = SEQ_ARMING * NUM_CMP * TGT_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               arm_i,
    input  logic               trig_i,
    input  logic               secure_i,
    input  logic               trace_en_i,
    input  logic               brk_en_i,
    input  logic [MAP_W-1:0]   next_map_i,
    input  logic [NUM_CMP-1:0] cmp_hit_i,
    input  logic [NUM_CMP-1:0] cmp_tag_i,
    input  logic               boundary_i,
    input  logic [NUM_CMP-1:0] tag_exec_i,
    output logic [TGT_W-1:0]   state_o,
    output logic               trace_start_o,
    output logic               brk_req_o
);
    logic [NUM_CMP-1:0] eff;
    logic               sel_valid;
    seq_state_e         sel_target;
    seq_state_e         state;

    dbg_seq_pend #(.NUM_CMP(NUM_CMP)) i_pend (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .arm_i      (arm_i),
        .hit_i      (cmp_hit_i),
        .tag_i      (cmp_tag_i),
        .boundary_i (boundary_i),
        .tag_exec_i (tag_exec_i),
        .eff_o      (eff)
    );

    dbg_seq_arb #(.NUM_CMP(NUM_CMP)) i_arb (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .state_i      (state),
        .eff_i        (eff),
        .map_i        (next_map_i),
        .sel_valid_o  (sel_valid),
        .sel_target_o (sel_target)
    );

    dbg_seq_fsm i_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .arm_i        (arm_i),
        .trig_i       (trig_i),
        .secure_i     (secure_i),
        .trace_en_i   (trace_en_i),
        .brk_en_i     (brk_en_i),
        .sel_valid_i  (sel_valid),
        .sel_target_i (sel_target),
        .state_o      (state),
        .trace_o      (trace_start_o),
        .brk_o        (brk_req_o)
    );

    assign state_o = state;
endmodule

// File: tb/test_dbg_trig_seq.sv
module test_dbg_trig_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0, trig = 1'b0, sec = 1'b0, ten = 1'b0, ben = 1'b0, bnd = 1'b0;
    logic [17:0] map_r = '0;
    logic [2:0]  hit = '0, tag = '0, tex = '0;
    logic [1:0]  state;
    logic        trace_p, brk_p;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [1:0] m_st = 2'd0;
    logic [2:0] m_pf = '0, m_pt = '0;
    logic       m_tr = 1'b0, m_bk = 1'b0;

    always #5 clk = ~clk;

    dbg_trig_seq i_dbg_trig_seq (
        .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .trig_i(trig), .secure_i(sec),
        .trace_en_i(ten), .brk_en_i(ben), .next_map_i(map_r), .cmp_hit_i(hit),
        .cmp_tag_i(tag), .boundary_i(bnd), .tag_exec_i(tex), .state_o(state),
        .trace_start_o(trace_p), .brk_req_o(brk_p)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic void set_tgt(input int s, input int c, input logic [1:0] t);
        map_r[(s*3+c)*2 +: 2] = t;
    endfunction

    // Reference model, one clock step from the present inputs
    task automatic model_step();
        logic [2:0] eff;
        logic [1:0] nst;
        logic       enter;
        eff = (m_pf & {3{bnd}}) | (m_pt & tex);
        nst = m_st;
        if (!arm) begin
            nst = 2'd0;
            m_pf = '0;
            m_pt = '0;
        end else begin
            if (m_st != 2'd3) begin
                if (trig) nst = 2'd3;
                else begin
                    for (int c = 2; c >= 0; c--)
                        if (eff[c]) nst = map_r[(int'(m_st)*3+c)*2 +: 2];
                end
            end
            m_pf = (m_pf & ~{3{bnd}}) | (hit & ~tag);
            m_pt = (m_pt & ~tex) | (hit & tag);
        end
        enter = (m_st != 2'd3) && (nst == 2'd3);
        m_tr = enter & ten & ~sec;
        m_bk = enter & ben;
        m_st = nst;
    endtask

    task automatic cyc(input logic a, input logic tr, input logic [2:0] h, input logic [2:0] tg,
                       input logic b, input logic [2:0] te);
        @(negedge clk);
        arm = a; trig = tr; hit = h; tag = tg; bnd = b; tex = te;
        model_step();
        @(posedge clk);
        #1;
        chk("R2 state", 32'(state), 32'(m_st));
        chk("R7 brk", 32'(brk_p), 32'(m_bk));
        chk("R7 trace", 32'(trace_p), 32'(m_tr));
    endtask

    task automatic idle(input logic a);
        cyc(a, 1'b0, 3'b000, 3'b000, 1'b0, 3'b000);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 state", 32'(state), 0);
        chk("R1 brk", 32'(brk_p), 0);
        chk("R1 trace", 32'(trace_p), 0);
        @(negedge clk);
        rst_n = 1'b1;
        ten = 1'b1; ben = 1'b1;

        // R3: force match, boundary in same cycle ignored, later boundary applies
        set_tgt(0, 0, 2'd2); set_tgt(0, 1, 2'd1); set_tgt(0, 2, 2'd0);
        idle(1'b1);
        cyc(1'b1, 1'b0, 3'b001, 3'b000, 1'b1, 3'b000);
        chk("R3 same-cycle boundary", 32'(state), 0);
        idle(1'b1); idle(1'b1);
        chk("R3 pending held", 32'(state), 0);
        cyc(1'b1, 1'b0, 3'b000, 3'b000, 1'b1, 3'b000);
        chk("R3 boundary applies", 32'(state), 2);

        // R10 disarm returns to first state
        idle(1'b0);
        chk("R10 disarm", 32'(state), 0);

        // R5 priority and R11 loser consumed
        set_tgt(2, 1, 2'd1);
        cyc(1'b1, 1'b0, 3'b011, 3'b000, 1'b0, 3'b000);
        cyc(1'b1, 1'b0, 3'b000, 3'b000, 1'b1, 3'b000);
        chk("R5 A over B", 32'(state), 2);
        cyc(1'b1, 1'b0, 3'b000, 3'b000, 1'b1, 3'b000);
        chk("R11 B consumed", 32'(state), 2);

        // R4 tag match waits for tag execute
        set_tgt(2, 2, 2'd3);
        cyc(1'b1, 1'b0, 3'b100, 3'b100, 1'b0, 3'b100);
        chk("R4 same-cycle exec", 32'(state), 2);
        cyc(1'b1, 1'b0, 3'b000, 3'b000, 1'b1, 3'b000);
        chk("R4 boundary no effect", 32'(state), 2);
        cyc(1'b1, 1'b0, 3'b000, 3'b000, 1'b0, 3'b100);
        chk("R4 exec applies", 32'(state), 3);
        chk("R7 brk pulse", 32'(brk_p), 1);
        chk("R7 trace pulse", 32'(trace_p), 1);
        idle(1'b1);
        chk("R7 brk one cycle", 32'(brk_p), 0);
        chk("R7 trace one cycle", 32'(trace_p), 0);

        // R9 Final holds against trig and matches
        cyc(1'b1, 1'b1, 3'b111, 3'b000, 1'b1, 3'b000);
        cyc(1'b1, 1'b1, 3'b000, 3'b000, 1'b1, 3'b111);
        chk("R9 hold", 32'(state), 3);
        chk("R9 no repulse", 32'(brk_p), 0);

        // R6 trig beats comparator, R8 secure blocks only trace
        idle(1'b0);
        set_tgt(0, 0, 2'd1);
        cyc(1'b1, 1'b0, 3'b001, 3'b000, 1'b0, 3'b000);
        sec = 1'b1;
        cyc(1'b1, 1'b1, 3'b000, 3'b000, 1'b1, 3'b000);
        chk("R6 trig", 32'(state), 3);
        chk("R8 brk kept", 32'(brk_p), 1);
        chk("R8 trace blocked", 32'(trace_p), 0);
        sec = 1'b0;

        // R10 pending discarded, trig ignored while disarmed
        idle(1'b0);
        cyc(1'b1, 1'b0, 3'b001, 3'b000, 1'b0, 3'b000);
        cyc(1'b0, 1'b1, 3'b001, 3'b000, 1'b0, 3'b000);
        chk("R10 trig ignored", 32'(state), 0);
        cyc(1'b1, 1'b0, 3'b000, 3'b000, 1'b1, 3'b000);
        chk("R10 pending cleared", 32'(state), 0);

        // R2 target equal to current state gives no move
        set_tgt(0, 1, 2'd0);
        cyc(1'b1, 1'b0, 3'b010, 3'b000, 1'b0, 3'b000);
        cyc(1'b1, 1'b0, 3'b000, 3'b000, 1'b1, 3'b000);
        chk("R2 self target", 32'(state), 0);

        // Random phase, compared each cycle with the model
        for (int i = 0; i < 4000; i++) begin
            if (i % 200 == 0) map_r = 18'($urandom());
            ten = ($urandom() % 4) != 0;
            ben = ($urandom() % 4) != 0;
            sec = ($urandom() % 5) == 0;
            cyc(($urandom() % 24) != 0, ($urandom() % 40) == 0, 3'($urandom()), 3'($urandom()),
                ($urandom() % 3) == 0, 3'($urandom() & $urandom()));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule